// File: doc/BRIEF.md
# Oversampled serial bit-clock front end

This block sits at the front of a synchronous serial slave. The remote master drives the serial bit clock, and it has no timing relation to the local system clock. The block samples that clock as ordinary data. It runs the clock through a two-stage synchronizer and a small two-state level tracker that acts as the delay stage. When the tracked level and the synchronized level differ, the block raises a rising-edge strobe or a falling-edge strobe for one system clock. The strobe appears a fixed three system clocks after the pin changes. No logic is clocked by the foreign clock.

The serial data input goes through a synchronizer of the same depth, so it stays aligned with the clock sample. On the sampling edge the block presents the received bit with a one-cycle valid pulse. On the opposite edge, the shift edge, it drives the next bit of a parallel transmit word onto the serial output, most significant bit first. A polarity input chooses which edge is the sampling edge.

The tracker has two states. ST_LOW takes transition RISE to ST_HIGH when the synchronized clock reads 1. ST_HIGH takes transition FALL to ST_LOW when it reads 0. Every other cycle holds the state. Reset puts the tracker in the idle level that the polarity input selects. The user must keep each bit-clock half period at 6 or more system clocks, so the full period is at least 12 system clocks.

Top module: `sclk_edge_front`

## Requirements
- R1: A change of `sclk_in` is flagged on `rise_stb` (0 to 1) or `fall_stb` (1 to 0) at exactly the third rising `clk` edge at which the new level is sampled. The strobe is high for the cycle that follows that edge.
- R2: Each change of `sclk_in` produces exactly one strobe pulse, one cycle long, of the matching direction. The two strobes are never high together.
- R3: Reset is synchronous and active high. It clears `rise_stb`, `fall_stb`, `rx_valid`, `rx_bit` and `sdo` to 0 and loads the clock synchronizer and tracker with the idle level (0 when `cpol_sel`=0, 1 when `cpol_sel`=1). While `sclk_in` stays at that idle level after reset, no strobe appears.
- R4: With `cpol_sel`=0 the sampling edge is the rising edge and the shift edge is the falling edge. With `cpol_sel`=1 the two are swapped.
- R5: `rx_valid` pulses for one cycle together with the sampling-edge strobe, and at no other time. `rx_bit` then equals the level of `sdi` at the `clk` edge where the new `sclk_in` level was first sampled, because `sdi` passes through the same two stages. `rx_bit` holds between pulses.
- R6: `sdo` changes only in the cycle of a shift-edge strobe. It then takes bit `tx_word[TX_W-1-n]`, where n is the number of shift edges since reset modulo `TX_W`, so the word goes out most significant bit first. `sdo` holds at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Serial bit clock from the remote master |
| sdi | input | 1 | Serial data input |
| cpol_sel | input | 1 | 0: sample on rise, shift on fall; 1: the reverse |
| tx_word | input | TX_W | Parallel word to transmit |
| rise_stb | output | 1 | One-cycle strobe for a rising bit-clock edge |
| fall_stb | output | 1 | One-cycle strobe for a falling bit-clock edge |
| rx_bit | output | 1 | Bit received on the last sampling edge |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_bit` |
| sdo | output | 1 | Serial data output |

## Verification
A tracker stuck in the wrong state, or a synchronizer loaded with the wrong level, shows up at the ports within three system clocks. The symptom is a missing, doubled or wrongly directed strobe, or one that comes a cycle early or late. A wrong polarity decode moves `rx_valid` onto the shift edge. A wrong bit index in the serializer puts a wrong `sdo` value on the very next shift edge, and a serializer that updates too often changes `sdo` between strobes. The bench therefore checks every cycle of every bit-clock half period, using random half periods. This catches a shift of even one cycle.

// File: rtl/sclk_fe_pkg.sv
package sclk_fe_pkg;
    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } lvl_state_t;
endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_val,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= rst_val;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= rst_val;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sclk_edge_fsm.sv
module sclk_edge_fsm
    import sclk_fe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic idle_lvl,
    input  logic lvl_sync,
    output logic rise_now,
    output logic fall_now,
    output logic rise_stb,
    output logic fall_stb
);
    lvl_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        rise_now = 1'b0;
        fall_now = 1'b0;
        unique case (state)
            ST_LOW: begin
                if (lvl_sync) begin       // transition RISE
                    state_nx = ST_HIGH;
                    rise_now = 1'b1;
                end
            end
            ST_HIGH: begin
                if (!lvl_sync) begin      // transition FALL
                    state_nx = ST_LOW;
                    fall_now = 1'b1;
                end
            end
            default: state_nx = ST_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= idle_lvl ? ST_HIGH : ST_LOW;
        else     state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            rise_stb <= rise_now;
            fall_stb <= fall_now;
        end
    end
endmodule

// File: rtl/sclk_data_path.sv
module sclk_data_path #(
    parameter int TX_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sample_now,
    input  logic            shift_now,
    input  logic            sdi_sync,
    input  logic [TX_W-1:0] tx_word,
    output logic            rx_bit,
    output logic            rx_valid,
    output logic            sdo
);
    localparam int IDX_W = (TX_W > 1) ? $clog2(TX_W) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TX_W - 1);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_bit   <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= sample_now;
            if (sample_now) rx_bit <= sdi_sync;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo <= 1'b0;
            idx <= '0;
        end else if (shift_now) begin
            sdo <= tx_word[LAST - idx];
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/sclk_edge_front.sv
module sclk_edge_front #(
    parameter int SYNC_STAGES = 2,
    parameter int TX_W        = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sclk_in,
    input  logic            sdi,
    input  logic            cpol_sel,
    input  logic [TX_W-1:0] tx_word,
    output logic            rise_stb,
    output logic            fall_stb,
    output logic            rx_bit,
    output logic            rx_valid,
    output logic            sdo
);
    logic sclk_s, sdi_s, rise_now, fall_now, sample_now, shift_now;

    sclk_sync #(.STAGES(SYNC_STAGES)) clk_sync_i (
        .clk(clk), .rst(rst), .rst_val(cpol_sel), .d(sclk_in), .q(sclk_s)
    );

    sclk_sync #(.STAGES(SYNC_STAGES)) dat_sync_i (
        .clk(clk), .rst(rst), .rst_val(1'b0), .d(sdi), .q(sdi_s)
    );

    sclk_edge_fsm fsm_i (
        .clk(clk), .rst(rst), .idle_lvl(cpol_sel), .lvl_sync(sclk_s),
        .rise_now(rise_now), .fall_now(fall_now),
        .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    assign sample_now = cpol_sel ? fall_now : rise_now;
    assign shift_now  = cpol_sel ? rise_now : fall_now;

    sclk_data_path #(.TX_W(TX_W)) dp_i (
        .clk(clk), .rst(rst), .sample_now(sample_now), .shift_now(shift_now),
        .sdi_sync(sdi_s), .tx_word(tx_word),
        .rx_bit(rx_bit), .rx_valid(rx_valid), .sdo(sdo)
    );
endmodule

// File: rtl/sclk_edge_front_chk.sv
module sclk_edge_front_chk (
    input logic clk,
    input logic rst,
    input logic sclk_in,
    input logic sdi,
    input logic cpol_sel,
    input logic rise_stb,
    input logic fall_stb,
    input logic rx_bit,
    input logic rx_valid,
    input logic sdo
);
    logic [2:0] since_rst;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end
    assign armed = (since_rst >= 3'd4);

    AST_RISE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        armed |-> (rise_stb == ($past(sclk_in, 3) && !$past(sclk_in, 4)))); // R1
    AST_FALL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        armed |-> (fall_stb == (!$past(sclk_in, 3) && $past(sclk_in, 4)))); // R1
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rise_stb && fall_stb)); // R2
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_stb |=> !rise_stb); // R2
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall_stb |=> !fall_stb); // R2
    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rise_stb && !fall_stb && !rx_valid && !sdo)); // R3
    AST_RXV_EDGE: assert property (@(posedge clk) disable iff (rst)
        armed |-> (rx_valid == ($past(cpol_sel) ? fall_stb : rise_stb))); // R4
    AST_RX_DATA: assert property (@(posedge clk) disable iff (rst)
        (armed && rx_valid) |-> (rx_bit == $past(sdi, 3))); // R5
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (armed && (sdo != $past(sdo))) |-> ($past(cpol_sel) ? rise_stb : fall_stb)); // R6
endmodule

bind sclk_edge_front sclk_edge_front_chk chk_i (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdi(sdi), .cpol_sel(cpol_sel),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .rx_bit(rx_bit),
    .rx_valid(rx_valid), .sdo(sdo)
);

// File: tb/sclk_edge_front_tb_top.sv
module sclk_edge_front_tb_top;
    localparam int TW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst, sclk_in, sdi, cpol_sel;
    logic [TW-1:0] tx_word;
    logic          rise_stb, fall_stb, rx_bit, rx_valid, sdo;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_idx;
    logic exp_sdo;

    sclk_edge_front #(.SYNC_STAGES(2), .TX_W(TW)) dut_i (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdi(sdi), .cpol_sel(cpol_sel),
        .tx_word(tx_word), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .rx_bit(rx_bit), .rx_valid(rx_valid), .sdo(sdo)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic pol, input logic pin);
        @(negedge clk);
        rst = 1'b1; cpol_sel = pol; sclk_in = pin; sdi = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_idx = 0;
        exp_sdo = 1'b0;
        chk("R3", "strobes after reset", int'({rise_stb, fall_stb}), 0);
        chk("R3", "rx after reset", int'({rx_valid, rx_bit}), 0);
        chk("R3", "sdo after reset", int'(sdo), 0);
    endtask

    task automatic idle_watch(input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rise_stb || fall_stb || rx_valid) seen++;
        end
        chk("R3", "no strobe while pin idle", seen, 0);
    endtask

    // called right after a negedge; changes the pin and watches one half period
    task automatic toggle(input logic new_sdi, input int half);
        logic rising, sampling, r3, f3, v3, b3, sdo2, sdo3;
        int   extra_stb = 0;
        int   extra_v = 0;
        sclk_in  = ~sclk_in;
        sdi      = new_sdi;
        rising   = sclk_in;
        sampling = (rising != cpol_sel);
        r3 = 1'b0; f3 = 1'b0; v3 = 1'b0; b3 = 1'b0; sdo2 = 1'b0; sdo3 = 1'b0;
        for (int i = 1; i <= half; i++) begin
            @(negedge clk);
            if (i == 3) begin
                r3 = rise_stb; f3 = fall_stb; v3 = rx_valid; b3 = rx_bit; sdo3 = sdo;
            end else begin
                if (rise_stb || fall_stb) extra_stb++;
                if (rx_valid) extra_v++;
                if (i == 2) sdo2 = sdo;
            end
        end
        chk("R1", "matching strobe at cycle 3", int'(rising ? r3 : f3), 1);
        chk("R2", "opposite strobe at cycle 3", int'(rising ? f3 : r3), 0);
        chk("R2", "strobes outside cycle 3", extra_stb, 0);
        chk("R5", "rx_valid outside cycle 3", extra_v, 0);
        chk("R4", "rx_valid on sampling edge only", int'(v3), int'(sampling));
        if (sampling) chk("R5", "rx_bit value", int'(b3), int'(new_sdi));
        chk("R6", "sdo held before strobe", int'(sdo2), int'(exp_sdo));
        if (!sampling) begin
            exp_sdo = tx_word[TW-1-exp_idx];
            exp_idx = (exp_idx == TW-1) ? 0 : exp_idx + 1;
        end
        chk("R6", "sdo at cycle 3", int'(sdo3), int'(exp_sdo));
    endtask

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [TW-1:0] words [3];
        words[0] = 8'hA5; words[1] = 8'h3C; words[2] = 8'hF0;
        rst = 1'b1; sclk_in = 1'b0; sdi = 1'b0; cpol_sel = 1'b0; tx_word = '0;
        for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < 3; w++) begin
                tx_word = words[w];
                do_reset(logic'(p), logic'(p));
                idle_watch(12);
                for (int t = 0; t < 3 * TW + 2; t++)
                    toggle(logic'($urandom_range(1, 0)), int'($urandom_range(13, 6)));
            end
        end
        // minimum half period sweep, both polarities
        for (int p = 0; p < 2; p++) begin
            tx_word = 8'h96;
            do_reset(logic'(p), logic'(p));
            for (int t = 0; t < 2 * TW; t++) toggle(logic'(t % 3 == 0), 6);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule